// File: doc/BRIEF.md
# Host Status/Control Register with Interrupt Latching

This block is a 16-bit host-visible register. It reads back one status layout and accepts writes in a different control layout at the same address. Each writable function has its own pair of control bits: one sets the function and one clears it. A host can therefore change one function without reading the register first. Writing zero to any bit does nothing.

Two one-cycle interrupt pulses from the bus protocol engine (message and fail) are captured in sticky latches. A latch stays set until the host writes a one to its acknowledge bit. The host IRQ line is raised while either latch is set and interrupts are enabled. With interrupts disabled, the host can still poll the latches.

The block also does three more things:
- It issues a fixed-length reset pulse to the engine when the host asks for it.
- It keeps a timer-resolution select.
- It keeps a host memory-page bit and an engine memory-page bit. The engine page follows the host page until automatic page switching is enabled, and then it is frozen.

The reset pulse is produced by a two-state machine:
- `RP_IDLE` moves to `RP_HOLD` when the host writes the reset bit.
- `RP_HOLD` stays in place until its down-counter reaches zero, and then returns to `RP_IDLE`.

Top module: `scr_status_ctl`

## Requirements
- R1: After reset, all stored state is zero. The status word then shows only the `eng_ready` and `eng_active` inputs, and `eng_reset` and `host_irq` are low.
- R2: Each writable function has a set bit and a clear bit, as (set, clear): interrupt enable (2, 3), subsystem flag (4, 5), timer select (8, 9), host page (12, 13), page-switch enable (14, 15). On a write, a one in the set bit sets the function and a one in the clear bit clears it. When both bits are one, the function is cleared. When both are zero, the function keeps its value.
- R3: A one-cycle `msg_pulse` sets status bit 0, and a `fail_pulse` sets status bit 1. Each latch holds until a write with a one in control bit 0 (message) or control bit 1 (fail).
- R4: If an interrupt pulse and the clearing write for the same latch occur in the same cycle, the latch ends up set.
- R5: The status word layout is: bit 0 message latch, bit 1 fail latch, bit 2 interrupt enable, bit 4 subsystem flag, bit 6 `eng_active`, bit 7 `eng_ready`, bit 8 timer select, bit 12 host page, bit 13 engine page, bit 14 page-switch enable. All other bits read zero.
- R6: `host_irq` is high exactly when interrupt enable is one and at least one interrupt latch is set.
- R7: A write with control bit 7 set drives `eng_reset` high for exactly RST_CYCLES cycles, starting at the clock edge of that write. A further bit-7 write during the pulse neither extends nor restarts it. Bit 7 changes no stored state.
- R8: The page-switch-enable set bit takes effect only while `mon_mode` is high. Its clear bit always takes effect.
- R9: While page switching is disabled, `eng_page` equals `pc_page`. While it is enabled, `eng_page` holds the host page that was in force before switching was enabled, and changes to `pc_page` do not affect it.
- R10: `timer_slow` gives the timer select: 0 selects the 250 kHz timer clock (4 µs resolution), and 1 selects the roughly 976 Hz clock (about 1.024 ms resolution).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 16 | Control word being written |
| msg_pulse | input | 1 | Message interrupt pulse from the engine |
| fail_pulse | input | 1 | Fail interrupt pulse from the engine |
| eng_ready | input | 1 | Engine ready indication |
| eng_active | input | 1 | Engine terminal-active indication |
| mon_mode | input | 1 | Engine is in monitor mode |
| status_word | output | 16 | Status word as read by the host |
| irq_enable | output | 1 | Interrupt enable state |
| subsys_flag | output | 1 | Subsystem flag state |
| timer_slow | output | 1 | Timer clock select (1 = slow clock) |
| pc_page | output | 1 | Host memory page |
| eng_page | output | 1 | Engine memory page |
| page_sw_en | output | 1 | Automatic page switching enabled |
| eng_reset | output | 1 | Reset pulse to the engine |
| host_irq | output | 1 | Host interrupt request |

## Verification
The assertions assume that the interrupt pulses and the write strobe are synchronous to `clk`, each lasting whole cycles. They also assume that `mon_mode` is stable over the write that sets page switching. The bench drives every input on the falling edge for exactly one cycle and keeps `mon_mode` fixed around each write. This meets those assumptions.

The bench tests each set/clear pair from both starting values with all four bit combinations. It tests every pulse/acknowledge pairing on both latches, and every IRQ-enable/latch combination. It compares the whole status word against a model that the bench maintains after every step.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned N_PAIRS = 5;

    // pair index: 0 irq enable, 1 subsystem flag, 2 timer select, 3 host page, 4 page-switch enable
    localparam int unsigned SET_POS [N_PAIRS] = '{2, 4, 8, 12, 14};
    localparam int unsigned CLR_POS [N_PAIRS] = '{3, 5, 9, 13, 15};
    localparam int unsigned PAIR_PSE = 4;

    localparam int unsigned ACK_MSG_POS  = 0;
    localparam int unsigned ACK_FAIL_POS = 1;
    localparam int unsigned RST_POS      = 7;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_HOLD = 1'b1
    } rp_state_e;
endpackage

// File: rtl/scr_setclr_bit.sv
module scr_setclr_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (clr_i) q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
    end

    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
    assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> q_o);
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/scr_irq_latch.sv
module scr_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic ack_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= 1'b0;
        else if (pulse_i) q_o <= 1'b1;
        else if (ack_i)   q_o <= 1'b0;
    end

    assert_pulse_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> q_o);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !ack_i) |=> q_o);
endmodule

// File: rtl/scr_reset_pulse.sv
module scr_reset_pulse
    import scr_pkg::*;
#(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic pulse_o
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] CNT_START = CW'(LEN - 1);

    rp_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (go_i)        state_d = RP_HOLD;
            RP_HOLD: if (cnt_q == '0) state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RP_IDLE) cnt_q <= CNT_START;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            RP_IDLE: pulse_o = 1'b0;
            RP_HOLD: pulse_o = 1'b1;
        endcase
    end

    assert_start_needs_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(go_i));
    assert_go_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !pulse_o) |=> pulse_o);
endmodule

// File: rtl/scr_status_ctl.sv
module scr_status_ctl
    import scr_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        msg_pulse,
    input  logic        fail_pulse,
    input  logic        eng_ready,
    input  logic        eng_active,
    input  logic        mon_mode,
    output logic [15:0] status_word,
    output logic        irq_enable,
    output logic        subsys_flag,
    output logic        timer_slow,
    output logic        pc_page,
    output logic        eng_page,
    output logic        page_sw_en,
    output logic        eng_reset,
    output logic        host_irq
);
    logic [N_PAIRS-1:0] set_v, clr_v, fn_q;
    logic msg_q, fail_q, frz_page_q;
    logic unused_wr;

    assign unused_wr = ^{wr_data[11:10], wr_data[6]};

    for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
        if (i == PAIR_PSE) begin : g_gated
            assign set_v[i] = wr_en & wr_data[SET_POS[i]] & mon_mode;
        end else begin : g_plain
            assign set_v[i] = wr_en & wr_data[SET_POS[i]];
        end
        assign clr_v[i] = wr_en & wr_data[CLR_POS[i]];
        scr_setclr_bit u_bit (
            .clk(clk), .rst_n(rst_n),
            .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(fn_q[i])
        );
    end

    scr_irq_latch u_msg (
        .clk(clk), .rst_n(rst_n), .pulse_i(msg_pulse),
        .ack_i(wr_en & wr_data[ACK_MSG_POS]), .q_o(msg_q)
    );
    scr_irq_latch u_fail (
        .clk(clk), .rst_n(rst_n), .pulse_i(fail_pulse),
        .ack_i(wr_en & wr_data[ACK_FAIL_POS]), .q_o(fail_q)
    );

    scr_reset_pulse #(.LEN(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n),
        .go_i(wr_en & wr_data[RST_POS]), .pulse_o(eng_reset)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          frz_page_q <= 1'b0;
        else if (!fn_q[PAIR_PSE]) frz_page_q <= fn_q[3];
    end

    assign irq_enable  = fn_q[0];
    assign subsys_flag = fn_q[1];
    assign timer_slow  = fn_q[2];
    assign pc_page     = fn_q[3];
    assign page_sw_en  = fn_q[PAIR_PSE];
    assign eng_page    = page_sw_en ? frz_page_q : pc_page;
    assign host_irq    = irq_enable & (msg_q | fail_q);

    always_comb begin
        status_word     = '0;
        status_word[0]  = msg_q;
        status_word[1]  = fail_q;
        status_word[2]  = irq_enable;
        status_word[4]  = subsys_flag;
        status_word[6]  = eng_active;
        status_word[7]  = eng_ready;
        status_word[8]  = timer_slow;
        status_word[12] = pc_page;
        status_word[13] = eng_page;
        status_word[14] = page_sw_en;
    end

    assert_pse_needs_mon_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_sw_en) |-> $past(mon_mode));
    assert_engpage_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (page_sw_en && $past(page_sw_en)) |-> $stable(eng_page));
endmodule

// File: tb/scr_status_ctl_test.sv
module scr_status_ctl_test;
    localparam int RSTC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic msg_pulse = 1'b0, fail_pulse = 1'b0;
    logic eng_ready = 1'b0, eng_active = 1'b0, mon_mode = 1'b0;
    logic [15:0] status_word;
    logic irq_enable, subsys_flag, timer_slow, pc_page, eng_page, page_sw_en, eng_reset, host_irq;

    int checks = 0, fails = 0, rhi = 0;
    bit done = 0;

    // model state
    bit m_ie, m_sub, m_tmr, m_pg, m_pse, m_frz, m_msg, m_fail;

    scr_status_ctl #(.RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .msg_pulse(msg_pulse), .fail_pulse(fail_pulse),
        .eng_ready(eng_ready), .eng_active(eng_active), .mon_mode(mon_mode),
        .status_word(status_word), .irq_enable(irq_enable), .subsys_flag(subsys_flag),
        .timer_slow(timer_slow), .pc_page(pc_page), .eng_page(eng_page),
        .page_sw_en(page_sw_en), .eng_reset(eng_reset), .host_irq(host_irq)
    );

    always #5 clk = ~clk;
    always @(negedge clk) if (eng_reset) rhi++;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        bit ep = m_pse ? m_frz : m_pg;
        s[0] = m_msg; s[1] = m_fail; s[2] = m_ie; s[4] = m_sub;
        s[6] = eng_active; s[7] = eng_ready; s[8] = m_tmr;
        s[12] = m_pg; s[13] = ep; s[14] = m_pse;
        return s;
    endfunction

    function automatic bit pair_next(bit old, bit s, bit c);
        return c ? 1'b0 : (s ? 1'b1 : old);
    endfunction

    task automatic check_all(string req);
        bit ep = m_pse ? m_frz : m_pg;
        chk(req, status_word, exp_status());
        chk(req, {irq_enable, subsys_flag, timer_slow, pc_page, eng_page, page_sw_en},
                 {m_ie, m_sub, m_tmr, m_pg, ep, m_pse});
        chk({req, " R6"}, host_irq, m_ie & (m_msg | m_fail));
    endtask

    task automatic step(string req, bit we, logic [15:0] w, bit mp, bit fp);
        if (!m_pse) m_frz = m_pg;
        @(negedge clk);
        wr_en = we; wr_data = w; msg_pulse = mp; fail_pulse = fp;
        @(negedge clk);
        wr_en = 0; wr_data = '0; msg_pulse = 0; fail_pulse = 0;
        if (we) begin
            m_ie  = pair_next(m_ie,  w[2],  w[3]);
            m_sub = pair_next(m_sub, w[4],  w[5]);
            m_tmr = pair_next(m_tmr, w[8],  w[9]);
            m_pg  = pair_next(m_pg,  w[12], w[13]);
            m_pse = pair_next(m_pse, w[14] & mon_mode, w[15]);
        end
        m_msg  = mp | (m_msg  & ~(we & w[0]));
        m_fail = fp | (m_fail & ~(we & w[1]));
        check_all(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", status_word, 16'h0000);
        chk("R1", {eng_reset, host_irq}, 2'b00);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R5: pass-through bits
        for (int k = 0; k < 4; k++) begin
            eng_ready = k[0]; eng_active = k[1];
            #1 check_all("R5");
        end
        eng_ready = 0; eng_active = 0;

        // R2 / R10: each non-gated pair, both starting values, all four bit combos
        for (int p = 0; p < 4; p++) begin
            int sp = (p == 0) ? 2 : (p == 1) ? 4 : (p == 2) ? 8 : 12;
            for (int init = 0; init < 2; init++)
                for (int c = 0; c < 4; c++) begin
                    logic [15:0] w0 = '0, w1 = '0;
                    w0[init ? sp : sp + 1] = 1'b1;
                    step("R2 init", 1, w0, 0, 0);
                    w1[sp] = c[0]; w1[sp + 1] = c[1];
                    step(p == 2 ? "R10" : "R2", 1, w1, 0, 0);
                end
        end

        // R8: page-switch enable gated by monitor mode
        mon_mode = 0; step("R8", 1, 16'h4000, 0, 0);
        mon_mode = 1; step("R8", 1, 16'h4000, 0, 0);
        mon_mode = 0; step("R8", 1, 16'hC000, 0, 0);

        // R9: engine page follows, then freezes
        step("R9", 1, 16'h1000, 0, 0);
        step("R9", 1, 16'h2000, 0, 0);
        step("R9", 1, 16'h1000, 0, 0);
        mon_mode = 1; step("R9", 1, 16'h6000, 0, 0);
        step("R9", 1, 16'h1000, 0, 0);
        step("R9", 1, 16'h2000, 0, 0);
        step("R9", 1, 16'h8000, 0, 0);
        mon_mode = 0;

        // R3 / R4: every pulse/ack pairing, both latches
        for (int src = 0; src < 2; src++)
            for (int pre = 0; pre < 2; pre++)
                for (int c = 0; c < 4; c++) begin
                    logic [15:0] a = '0;
                    a[src] = 1'b1;
                    if (pre) step("R3 pre", 0, '0, src == 0, src == 1);
                    else     step("R3 pre", 1, a, 0, 0);
                    a[src] = c[1];
                    step((c == 3) ? "R4" : "R3", c[1], a, c[0] & (src == 0), c[0] & (src == 1));
                    step("R3 hold", 0, '0, 0, 0);
                end
        step("R3", 1, 16'h0003, 0, 0);

        // R6: enable x latch combinations
        for (int ie = 0; ie < 2; ie++)
            for (int l = 0; l < 4; l++) begin
                step("R6 ie", 1, ie ? 16'h0007 : 16'h000B, 0, 0);
                step("R6", 0, '0, l[0], l[1]);
            end
        step("R6", 1, 16'h0003, 0, 0);

        // R7: reset pulse length, no retrigger, no state change
        rhi = 0;
        step("R7", 1, 16'h0080, 0, 0);
        repeat (RSTC + 3) @(negedge clk);
        chk("R7", 16'(rhi), 16'(RSTC));
        rhi = 0;
        step("R7", 1, 16'h0080, 0, 0);
        step("R7", 1, 16'h0080, 0, 0);
        repeat (RSTC + 3) @(negedge clk);
        chk("R7", 16'(rhi), 16'(RSTC));
        chk("R7", eng_reset, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule